// File: doc/BRIEF.md
# Multi-Port GPIO Register Bank

This block is a memory-mapped GPIO bank that sits on an APB bus. It serves up to four ports, each up to 32 lines wide. Every port has three registers. The output-value register drives the pad output lines. The output-enable register selects, bit by bit, which lines are driven. The read-only pin register returns the pad levels after a two-stage synchronizer. The number of ports and the width of each port are parameters. A further parameter picks one of two address layouts. Interrupt generation, debouncing, pads and tri-state cells live outside this block.

In the standard layout the output-value and output-enable registers of port p sit at `p*0x0C` and `p*0x0C + 0x04`. In the compact layout they sit at `p*0x08` and `p*0x08 + 0x04`. In both layouts the pin register of port p sits at `0x50 + p*4`. Every access is a whole 32-bit word. The block has no data stream and never applies back-pressure: an APB transfer always completes in its access phase, with no wait states and no error response.

Top module: `gpio_bank`

## Requirements
- R1: After reset the output-value and output-enable registers of every port are zero, so `gpio_out` and `gpio_oe` are all zero and every line starts as an input.
- R2: A write to the output-value register of port p is stored at the clock edge of the access phase. From the next cycle the value appears on `gpio_out[p*32 +: 32]` and reads back at the same address.
- R3: A write to the output-enable register of port p is stored at the clock edge of the access phase. Each bit equal to 1 makes its line an output: `gpio_oe[p*32+i]` equals bit i of that register.
- R4: A read of the pin register of port p returns the `gpio_in` lines of that port after two flop stages. It never returns the output-value register. A pad change made just before the first of the two edges is not yet visible in a read sampled between those edges.
- R5: Bits at or above a port's configured width read as zero in all three registers. Writes to those bits are dropped, and the matching `gpio_out` and `gpio_oe` bits stay zero.
- R6: Addresses of ports at or beyond `NUM_PORTS`, addresses that map to no register, and addresses that are not word-aligned all read as zero. Writes to them change no output.
- R7: `pready` is 1 and `pslverr` is 0 in every access.
- R8: With `ALT_LAYOUT` = 1, the output-value and output-enable registers of port p sit at `p*8` and `p*8+4`. The pin registers stay at `0x50 + p*4`.
- R9: A register changes only on a cycle where `psel`, `penable` and `pwrite` are all high. A setup phase held without `penable` has no effect.
- R10: A write to a pin register is ignored. The register goes on returning the synchronized pad levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and register clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Select for this slave |
| penable | input | 1 | Access-phase indicator |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address within the bank |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always 1 (no wait states) |
| pslverr | output | 1 | Always 0 (no error response) |
| gpio_in | input | NUM_PORTS*32 | Pad input levels, port p at bits p*32 upward |
| gpio_out | output | NUM_PORTS*32 | Pad output values |
| gpio_oe | output | NUM_PORTS*32 | Pad output enables, 1 = drive |

## Verification
The pad synchronizer runs every cycle, independent of the bus. It can capture a new pad level on the same edge that stores a write to the output-value register of the same port. The bench provokes this by changing `gpio_in` on the same falling edge that raises `penable` for a write to port A's output-value register. It then judges the two paths separately. `gpio_out` and a read of the output-value register must show the written word, while the later read of the pin register must show the new pad level and not the written one. The first sampling edge after a pad change is also probed, to confirm the old value is still returned there.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int unsigned MAX_PORTS  = 4;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned PIN_BASE   = 'h50;
  localparam int unsigned PIN_STRIDE = 4;
  localparam int unsigned STRIDE_STD = 12;
  localparam int unsigned STRIDE_ALT = 8;
  localparam int unsigned OE_OFFSET  = 4;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_OUT  = 2'd1,
    KIND_OE   = 2'd2,
    KIND_PIN  = 2'd3
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e   kind;
    logic [1:0]  port;
  } reg_sel_t;

endpackage

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
  import gpio_bank_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned NUM_PORTS  = 3,
  parameter bit          ALT_LAYOUT = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);

  localparam int unsigned STRIDE = ALT_LAYOUT ? STRIDE_ALT : STRIDE_STD;

  always_comb begin
    sel.kind = KIND_NONE;
    sel.port = 2'd0;
    for (int unsigned p = 0; p < MAX_PORTS; p++) begin
      if (p < NUM_PORTS) begin
        if (addr == ADDR_W'(p * STRIDE)) begin
          sel.kind = KIND_OUT;
          sel.port = 2'(p);
        end
        if (addr == ADDR_W'(p * STRIDE + OE_OFFSET)) begin
          sel.kind = KIND_OE;
          sel.port = 2'(p);
        end
        if (addr == ADDR_W'(PIN_BASE + p * PIN_STRIDE)) begin
          sel.kind = KIND_PIN;
          sel.port = 2'(p);
        end
      end
    end
  end

  always_comb begin
    if (sel.kind != KIND_NONE) begin
      AST_DECODE_IN_RANGE: assert (int'(sel.port) < int'(NUM_PORTS)); // R6
    end
  end

endmodule

// File: rtl/gpio_bank_port.sv
module gpio_bank_port #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_out,
  input  logic             wr_oe,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] out_q,
  output logic [WIDTH-1:0] oe_q,
  output logic [WIDTH-1:0] pin_q
);

  logic [WIDTH-1:0] sync_s1;
  logic [WIDTH-1:0] sync_s2;
  logic [1:0]       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      oe_q  <= '0;
    end else begin
      if (wr_out) out_q <= wdata;
      if (wr_oe)  oe_q  <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_s1 <= '0;
      sync_s2 <= '0;
    end else begin
      sync_s1 <= pad_in;
      sync_s2 <= sync_s1;
    end
  end

  assign pin_q = sync_s2;

  // cycles since reset, saturating at 2, used only to qualify checks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           warm <= 2'd0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  AST_OUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n) wr_out |=> out_q == $past(wdata)); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !wr_out |=> $stable(out_q)); // R9
  AST_OE_LOAD: assert property (@(posedge clk) disable iff (!rst_n) wr_oe |=> oe_q == $past(wdata)); // R3
  AST_PIN_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) (warm == 2'd2) |-> pin_q == $past(pad_in, 2)); // R4

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PORTS               = 3,
  parameter int unsigned PORT_WIDTH [MAX_PORTS]  = '{32, 12, 8, 32},
  parameter bit          ALT_LAYOUT              = 1'b0,
  parameter int unsigned ADDR_W                  = 8
) (
  input  logic                        pclk,
  input  logic                        presetn,
  input  logic                        psel,
  input  logic                        penable,
  input  logic                        pwrite,
  input  logic [ADDR_W-1:0]           paddr,
  input  logic [WORD_W-1:0]           pwdata,
  output logic [WORD_W-1:0]           prdata,
  output logic                        pready,
  output logic                        pslverr,
  input  logic [NUM_PORTS*WORD_W-1:0] gpio_in,
  output logic [NUM_PORTS*WORD_W-1:0] gpio_out,
  output logic [NUM_PORTS*WORD_W-1:0] gpio_oe
);

  reg_sel_t          sel;
  logic              wr_en;
  logic [WORD_W-1:0] rd_out [MAX_PORTS];
  logic [WORD_W-1:0] rd_oe  [MAX_PORTS];
  logic [WORD_W-1:0] rd_pin [MAX_PORTS];
  logic              unused_wdata;

  gpio_bank_decode #(
    .ADDR_W    (ADDR_W),
    .NUM_PORTS (NUM_PORTS),
    .ALT_LAYOUT(ALT_LAYOUT)
  ) u_decode (
    .addr(paddr),
    .sel (sel)
  );

  assign wr_en        = psel & penable & pwrite;
  assign unused_wdata = ^pwdata;

  for (genvar p = 0; p < MAX_PORTS; p++) begin : g_slot
    if (p < NUM_PORTS) begin : g_port
      localparam int unsigned W = PORT_WIDTH[p];
      logic         hit;
      logic [W-1:0] out_q;
      logic [W-1:0] oe_q;
      logic [W-1:0] pin_q;

      assign hit = (sel.port == 2'(p));

      gpio_bank_port #(.WIDTH(W)) u_port (
        .clk   (pclk),
        .rst_n (presetn),
        .wr_out(wr_en && hit && sel.kind == KIND_OUT),
        .wr_oe (wr_en && hit && sel.kind == KIND_OE),
        .wdata (pwdata[W-1:0]),
        .pad_in(gpio_in[p*WORD_W +: W]),
        .out_q (out_q),
        .oe_q  (oe_q),
        .pin_q (pin_q)
      );

      assign rd_out[p] = WORD_W'(out_q);
      assign rd_oe[p]  = WORD_W'(oe_q);
      assign rd_pin[p] = WORD_W'(pin_q);
      assign gpio_out[p*WORD_W +: WORD_W] = WORD_W'(out_q);
      assign gpio_oe[p*WORD_W +: WORD_W]  = WORD_W'(oe_q);

      if (W < WORD_W) begin : g_narrow
        logic unused_pad_hi;
        assign unused_pad_hi = ^gpio_in[p*WORD_W+W +: WORD_W-W];
        AST_UPPER_ZERO: assert property (@(posedge pclk) disable iff (!presetn) (psel && !pwrite && hit && sel.kind != KIND_NONE) |-> (prdata >> W) == '0); // R5
      end
    end else begin : g_absent
      assign rd_out[p] = '0;
      assign rd_oe[p]  = '0;
      assign rd_pin[p] = '0;
    end
  end

  always_comb begin
    unique case (sel.kind)
      KIND_OUT: prdata = rd_out[sel.port];
      KIND_OE:  prdata = rd_oe[sel.port];
      KIND_PIN: prdata = rd_pin[sel.port];
      default:  prdata = '0;
    endcase
  end

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  AST_UNMAPPED_ZERO: assert property (@(posedge pclk) disable iff (!presetn) (psel && !pwrite && sel.kind == KIND_NONE) |-> prdata == '0); // R6
  AST_NO_STRAY_WRITE: assert property (@(posedge pclk) disable iff (!presetn) !(psel && penable && pwrite) |=> ($stable(gpio_out) && $stable(gpio_oe))); // R9

endmodule

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;

  localparam int NP = 3;
  localparam int BW = NP * 32;

  logic          clk = 1'b0;
  logic          presetn = 1'b0;
  logic          psel_m = 1'b0, psel_a = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]    paddr = '0;
  logic [31:0]   pwdata = '0;
  logic [31:0]   prdata_m, prdata_a;
  logic          pready_m, pready_a, pslverr_m, pslverr_a;
  logic [BW-1:0] gpio_in_m = '0, gpio_in_a = '0;
  logic [BW-1:0] gpio_out_m, gpio_oe_m, gpio_out_a, gpio_oe_a;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  gpio_bank #(.NUM_PORTS(NP), .ALT_LAYOUT(1'b0)) u_dut (
    .pclk(clk), .presetn(presetn), .psel(psel_m), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata_m), .pready(pready_m), .pslverr(pslverr_m),
    .gpio_in(gpio_in_m), .gpio_out(gpio_out_m), .gpio_oe(gpio_oe_m)
  );

  gpio_bank #(.NUM_PORTS(NP), .ALT_LAYOUT(1'b1)) u_alt (
    .pclk(clk), .presetn(presetn), .psel(psel_a), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata_a), .pready(pready_a), .pslverr(pslverr_a),
    .gpio_in(gpio_in_a), .gpio_out(gpio_out_a), .gpio_oe(gpio_oe_a)
  );

  task automatic chk(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit to_alt, input bit wr, input logic [7:0] a,
                      input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    psel_m = !to_alt; psel_a = to_alt; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    #1;
    q = to_alt ? prdata_a : prdata_m;
    chk("R7", BW'({to_alt ? pready_a : pready_m, to_alt ? pslverr_a : pslverr_m}), BW'(2'b10));
    @(posedge clk);
    #1;
    psel_m = 1'b0; psel_a = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic wr(input bit to_alt, input logic [7:0] a, input logic [31:0] d);
    logic [31:0] q;
    xfer(to_alt, 1'b1, a, d, q);
  endtask

  task automatic rd_chk(input bit to_alt, input logic [7:0] a, input logic [31:0] exp, input string req);
    logic [31:0] q;
    xfer(to_alt, 1'b0, a, 32'h0, q);
    chk(req, BW'(q), BW'(exp));
  endtask

  task automatic t_reset();
    chk("R1 out", gpio_out_m, '0);
    chk("R1 oe", gpio_oe_m, '0);
    chk("R1 alt oe", gpio_oe_a, '0);
    rd_chk(1'b0, 8'h00, 32'h0, "R1 outA");
    rd_chk(1'b0, 8'h04, 32'h0, "R1 oeA");
    rd_chk(1'b0, 8'h10, 32'h0, "R1 oeB");
    rd_chk(1'b0, 8'h1C, 32'h0, "R1 oeC");
  endtask

  task automatic t_out_oe();
    wr(1'b0, 8'h00, 32'hA5A5_0F0F);
    chk("R2 padA", BW'(gpio_out_m[31:0]), BW'(32'hA5A5_0F0F));
    rd_chk(1'b0, 8'h00, 32'hA5A5_0F0F, "R2 readA");
    wr(1'b0, 8'h04, 32'hFFFF_0000);
    chk("R3 oeA", BW'(gpio_oe_m[31:0]), BW'(32'hFFFF_0000));
    wr(1'b0, 8'h0C, 32'hFFFF_FFFF);
    chk("R5 padB", BW'(gpio_out_m[63:32]), BW'(32'h0000_0FFF));
    rd_chk(1'b0, 8'h0C, 32'h0000_0FFF, "R5 readB");
    wr(1'b0, 8'h1C, 32'hFFFF_FF3C);
    chk("R3 oeC", BW'(gpio_oe_m[95:64]), BW'(32'h3C));
    rd_chk(1'b0, 8'h1C, 32'h3C, "R5 readC");
  endtask

  task automatic t_pin();
    @(negedge clk);
    gpio_in_m[31:0] = 32'h1234_5678;
    psel_m = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = 8'h50;
    @(negedge clk);
    penable = 1'b1;
    #1;
    chk("R4 one edge old", BW'(prdata_m), '0);
    @(posedge clk);
    #1;
    psel_m = 1'b0; penable = 1'b0;
    rd_chk(1'b0, 8'h50, 32'h1234_5678, "R4 pinA not out reg");
    gpio_in_m[63:32] = 32'hFFFF_FFFF;
    rd_chk(1'b0, 8'h54, 32'h0, "R4 pinB before sync");
    rd_chk(1'b0, 8'h54, 32'h0000_0FFF, "R5 pinB width");
  endtask

  task automatic t_unmapped();
    logic [BW-1:0] snap_o, snap_e;
    snap_o = gpio_out_m; snap_e = gpio_oe_m;
    rd_chk(1'b0, 8'h24, 32'h0, "R6 portD out");
    rd_chk(1'b0, 8'h5C, 32'h0, "R6 portD pin");
    rd_chk(1'b0, 8'h08, 32'h0, "R6 hole");
    rd_chk(1'b0, 8'h01, 32'h0, "R6 unaligned");
    wr(1'b0, 8'h24, 32'hFFFF_FFFF);
    wr(1'b0, 8'h08, 32'hFFFF_FFFF);
    wr(1'b0, 8'h02, 32'hFFFF_FFFF);
    chk("R6 out untouched", gpio_out_m, snap_o);
    chk("R6 oe untouched", gpio_oe_m, snap_e);
    wr(1'b0, 8'h50, 32'h0);
    rd_chk(1'b0, 8'h50, 32'h1234_5678, "R10 pin write ignored");
  endtask

  task automatic t_setup_only();
    logic [BW-1:0] snap;
    snap = gpio_out_m;
    @(negedge clk);
    psel_m = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 8'h00; pwdata = 32'h0;
    repeat (3) @(negedge clk);
    psel_m = 1'b0; pwrite = 1'b0;
    @(negedge clk);
    chk("R9 setup only", gpio_out_m, snap);
  endtask

  task automatic t_collide();
    logic [31:0] q;
    @(negedge clk);
    psel_m = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 8'h00; pwdata = 32'h0F0F_F0F0;
    @(negedge clk);
    penable = 1'b1;
    gpio_in_m[31:0] = 32'hCAFE_0001;
    @(posedge clk);
    #1;
    psel_m = 1'b0; penable = 1'b0; pwrite = 1'b0;
    chk("R2 collide out", BW'(gpio_out_m[31:0]), BW'(32'h0F0F_F0F0));
    xfer(1'b0, 1'b0, 8'h50, 32'h0, q);
    chk("R4 collide pin", BW'(q), BW'(32'hCAFE_0001));
    rd_chk(1'b0, 8'h00, 32'h0F0F_F0F0, "R2 collide readback");
  endtask

  task automatic t_alt();
    logic [BW-1:0] snap;
    snap = gpio_out_m;
    wr(1'b1, 8'h08, 32'h0000_0ABC);
    chk("R8 alt outB", BW'(gpio_out_a[63:32]), BW'(32'hABC));
    wr(1'b1, 8'h0C, 32'hFFFF_FFFF);
    chk("R8 alt oeB", BW'(gpio_oe_a[63:32]), BW'(32'hFFF));
    rd_chk(1'b1, 8'h0C, 32'h0000_0FFF, "R8 alt read oeB");
    wr(1'b1, 8'h10, 32'h0000_005A);
    chk("R8 alt outC", BW'(gpio_out_a[95:64]), BW'(32'h5A));
    rd_chk(1'b1, 8'h18, 32'h0, "R8 alt portD absent");
    chk("R8 main untouched", gpio_out_m, snap);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    presetn = 1'b1;
    t_reset();
    t_out_oe();
    t_pin();
    t_unmapped();
    t_setup_only();
    t_collide();
    t_alt();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule